// File: doc/BRIEF.md
# PLL Bring-Up Sequencer

This block is a state machine running on the reference clock. It drives the control lines of an external PLL and its clock dividers, so that firmware does not have to write each bring-up step in turn. A request names a target mode, either locked PLL or bypass. It also carries a reference-type select, a pre-divider, a post-divider, a multiplier and a set of output-divider ratios. The sequencer then steps the mux select, PLL reset, PLL disable and power-down lines in a fixed order. It honours three minimum waits:

- mux settling, counted in reference cycles;
- reset hold, computed from the reference frequency and a time in microseconds;
- lock time, counted in reference cycles.

It loads the divider values and strobes the divider update once.

Going to PLL mode covers the whole path: bypass, reset, power-up, load, wait for lock, then switch to the PLL output. Going to bypass only parks the mux, holds the PLL in reset and refreshes the output dividers. The multiplier settings and power state are left alone. The sequencer is busy for the whole run and gives a single done pulse at the end.

Top module: `pll_seq_ctrl`

## Requirements
- R1: While reset is active, and after it, the outputs rest as follows: pll_en 0 (bypass), pll_rst 1, pll_dis 1, pll_pwrdn 1, div_go 0, busy 0, done 0, ref_sq 0, en_src_pin 1, and all divider outputs 0.
- R2: Call acceptance edge A the clock edge at which req_valid is sampled high while idle. One edge after A, ref_sq takes the requested type (0 = internal oscillator, 1 = square-wave input), and en_src_pin drops to 0 so that pll_en becomes effective. No other output has changed before this.
- R3: One edge after R2, pll_en is driven to 0. pll_rst rises exactly MUX_CYC+1 cycles later.
- R4: In PLL mode these steps follow on consecutive edges after pll_rst rises: pll_dis goes to 1, then pll_pwrdn goes to 0, then pll_dis goes to 0.
- R5: In PLL mode, prediv_o, postdiv_o and mult_o take the requested values one edge after pll_dis is released. outdiv_o (NUM_ODIV fields of ODIV_W bits, field 0 in the low bits) takes its values on the following edge.
- R6: div_go is high for exactly one cycle. That cycle is the one right after outdiv_o is updated, in both modes.
- R7: In PLL mode, pll_rst stays high for RST_CYC+7 cycles. RST_CYC is ceil(REF_FREQ_HZ*RST_US/1e6).
- R8: In PLL mode, pll_en rises to 1 exactly LOCK_CYC+1 cycles after pll_rst falls.
- R9: In bypass mode, outdiv_o is updated one edge after pll_rst rises, and div_go follows. prediv_o, postdiv_o, mult_o, pll_dis, pll_pwrdn and pll_en keep their values.
- R10: busy is high from one edge after A until the final step. done is a single-cycle pulse with busy low. It comes MUX_CYC+RST_CYC+LOCK_CYC+13 cycles after A in PLL mode and MUX_CYC+7 cycles after A in bypass mode.
- R11: A request made while busy is ignored. The running sequence keeps the values and mode of the accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request strobe, taken only while idle |
| req_pll | input | 1 | 1 = bring up PLL mode, 0 = bypass mode |
| req_ref_sq | input | 1 | Reference type: 0 internal oscillator, 1 square-wave clock |
| req_prediv | input | PRE_W | Requested pre-divider |
| req_postdiv | input | POST_W | Requested post-divider |
| req_mult | input | MULT_W | Requested multiplier |
| req_outdiv | input | NUM_ODIV*ODIV_W | Requested output-divider ratios |
| ref_sq | output | 1 | Reference-type select to the PLL |
| en_src_pin | output | 1 | 1 = enable taken from a pin, 0 = pll_en effective |
| pll_en | output | 1 | Mux select: 0 bypass, 1 PLL output |
| pll_rst | output | 1 | PLL reset |
| pll_dis | output | 1 | PLL disable |
| pll_pwrdn | output | 1 | PLL power-down |
| prediv_o | output | PRE_W | Pre-divider to the PLL |
| postdiv_o | output | POST_W | Post-divider to the PLL |
| mult_o | output | MULT_W | Multiplier to the PLL |
| outdiv_o | output | NUM_ODIV*ODIV_W | Output-divider ratios |
| div_go | output | 1 | One-cycle divider update strobe |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with REF_FREQ_HZ = 2 MHz, which gives a reset hold of 10 cycles, with LOCK_CYC = 20 and MUX_CYC = 4. With these values a full PLL bring-up takes under fifty cycles. Every output can then be compared against an arithmetic model on every cycle of every run. The bench sweeps both modes, both reference types and several divider patterns, in an order where bypass follows PLL and PLL follows bypass. This covers transitions from each prior state. Stray requests during a run and a reset in the middle of a sequence are also exercised.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_REF, ST_BYP, ST_WMUX, ST_RSTON, ST_DISON, ST_PWRUP, ST_DISOFF,
    ST_LDPLL, ST_LDDIV, ST_GO, ST_WRST, ST_RSTOFF, ST_WLOCK, ST_PLLON, ST_FIN
  } seq_st_e;

  // Rounds up: cycles of freq_hz needed to cover us microseconds.
  function automatic int unsigned us_to_cycles(input longint unsigned freq_hz,
                                               input longint unsigned us);
    longint unsigned prod;
    prod = freq_hz * us + 64'd999_999;
    return 32'(prod / 64'd1_000_000);
  endfunction

endpackage

// File: rtl/pll_seq_rst_sync.sv
module pll_seq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_no
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_no = sync_q[1];
endmodule

// File: rtl/pll_seq_wait_timer.sv
module pll_seq_wait_timer #(
  parameter int unsigned TW = 4
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [TW-1:0] val_i,
  output logic          zero_o
);
  logic [TW-1:0] cnt_q;
  logic [TW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = load_i || (cnt_q != '0);
    cnt_d  = load_i ? val_i : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign zero_o = (cnt_q == '0);

  AST_TMR_DECR: assert property (@(posedge clk) disable iff (!rst_ni)
    (!$past(load_i) && $past(cnt_q) != '0) |-> cnt_q == $past(cnt_q) - 1'b1); // R3
endmodule

// File: rtl/pll_seq_fsm.sv
module pll_seq_fsm
  import pll_seq_pkg::*;
#(
  parameter int unsigned MUX_CYC  = 4,
  parameter int unsigned RST_CYC  = 125,
  parameter int unsigned LOCK_CYC = 8000,
  parameter int unsigned TW       = 14
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  input  logic          req_pll_i,
  input  logic          tmr_zero_i,
  output logic          tmr_load_o,
  output logic [TW-1:0] tmr_val_o,
  output seq_st_e       st_o,
  output logic          accept_o,
  output logic          busy_o,
  output logic          done_o
);
  seq_st_e st_q, st_d;
  logic    mode_q;
  logic    busy_q, busy_d, busy_en;
  logic    done_q;

  assign accept_o = (st_q == ST_IDLE) && req_valid_i;

  always_comb begin
    st_d       = st_q;
    tmr_load_o = 1'b0;
    tmr_val_o  = '0;
    unique case (st_q)
      ST_IDLE:   if (req_valid_i) st_d = ST_REF;
      ST_REF:    st_d = ST_BYP;
      ST_BYP: begin
        st_d       = ST_WMUX;
        tmr_load_o = 1'b1;
        tmr_val_o  = TW'(MUX_CYC - 1);
      end
      ST_WMUX:   if (tmr_zero_i) st_d = ST_RSTON;
      ST_RSTON:  st_d = mode_q ? ST_DISON : ST_LDDIV;
      ST_DISON:  st_d = ST_PWRUP;
      ST_PWRUP:  st_d = ST_DISOFF;
      ST_DISOFF: st_d = ST_LDPLL;
      ST_LDPLL:  st_d = ST_LDDIV;
      ST_LDDIV:  st_d = ST_GO;
      ST_GO: begin
        if (mode_q) begin
          st_d       = ST_WRST;
          tmr_load_o = 1'b1;
          tmr_val_o  = TW'(RST_CYC - 1);
        end else begin
          st_d = ST_FIN;
        end
      end
      ST_WRST:   if (tmr_zero_i) st_d = ST_RSTOFF;
      ST_RSTOFF: begin
        st_d       = ST_WLOCK;
        tmr_load_o = 1'b1;
        tmr_val_o  = TW'(LOCK_CYC - 1);
      end
      ST_WLOCK:  if (tmr_zero_i) st_d = ST_PLLON;
      ST_PLLON:  st_d = ST_FIN;
      ST_FIN:    st_d = ST_IDLE;
      default:   st_d = ST_IDLE;
    endcase
  end

  always_comb begin
    busy_en = accept_o || (st_q == ST_FIN);
    busy_d  = accept_o;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      mode_q <= 1'b0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= (st_q == ST_FIN);
      if (accept_o) mode_q <= req_pll_i;
      if (busy_en)  busy_q <= busy_d;
    end
  end

  assign st_o   = st_q;
  assign busy_o = busy_q;
  assign done_o = done_q;

  AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_ni)
    !(busy_q && done_q)); // R10
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_ni)
    done_q |=> !done_q); // R10
  AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_ni)
    busy_q |-> !accept_o); // R11
  AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_ni)
    (busy_q && $past(busy_q)) |-> $stable(mode_q)); // R11
endmodule

// File: rtl/pll_seq_out_regs.sv
module pll_seq_out_regs
  import pll_seq_pkg::*;
#(
  parameter int unsigned MUX_CYC  = 4,
  parameter int unsigned PRE_W    = 5,
  parameter int unsigned POST_W   = 5,
  parameter int unsigned MULT_W   = 8,
  parameter int unsigned ODIV_W   = 5,
  parameter int unsigned NUM_ODIV = 3,
  localparam int unsigned OD_TOT  = NUM_ODIV * ODIV_W
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  seq_st_e           st_i,
  input  logic              accept_i,
  input  logic              req_ref_sq_i,
  input  logic [PRE_W-1:0]  req_prediv_i,
  input  logic [POST_W-1:0] req_postdiv_i,
  input  logic [MULT_W-1:0] req_mult_i,
  input  logic [OD_TOT-1:0] req_outdiv_i,
  output logic              ref_sq_o,
  output logic              en_src_pin_o,
  output logic              pll_en_o,
  output logic              pll_rst_o,
  output logic              pll_dis_o,
  output logic              pll_pwrdn_o,
  output logic [PRE_W-1:0]  prediv_o,
  output logic [POST_W-1:0] postdiv_o,
  output logic [MULT_W-1:0] mult_o,
  output logic [OD_TOT-1:0] outdiv_o,
  output logic              div_go_o
);
  localparam int unsigned AGE_W = $clog2(MUX_CYC + 2) + 1;

  // Captured request
  logic              cap_ref_q;
  logic [PRE_W-1:0]  cap_pre_q;
  logic [POST_W-1:0] cap_post_q;
  logic [MULT_W-1:0] cap_mult_q;
  logic [OD_TOT-1:0] cap_od_q;

  // Step enables
  logic en_ref, en_mux, en_rst, en_dis, en_pwr, en_pll, en_od;
  logic mux_d, rst_d, dis_d;

  always_comb begin
    en_ref = (st_i == ST_REF);
    en_mux = (st_i == ST_BYP) || (st_i == ST_PLLON);
    mux_d  = (st_i == ST_PLLON);
    en_rst = (st_i == ST_RSTON) || (st_i == ST_RSTOFF);
    rst_d  = (st_i == ST_RSTON);
    en_dis = (st_i == ST_DISON) || (st_i == ST_DISOFF);
    dis_d  = (st_i == ST_DISON);
    en_pwr = (st_i == ST_PWRUP);
    en_pll = (st_i == ST_LDPLL);
    en_od  = (st_i == ST_LDDIV);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_ref_q  <= 1'b0;
      cap_pre_q  <= '0;
      cap_post_q <= '0;
      cap_mult_q <= '0;
      cap_od_q   <= '0;
    end else if (accept_i) begin
      cap_ref_q  <= req_ref_sq_i;
      cap_pre_q  <= req_prediv_i;
      cap_post_q <= req_postdiv_i;
      cap_mult_q <= req_mult_i;
      cap_od_q   <= req_outdiv_i;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_sq_o     <= 1'b0;
      en_src_pin_o <= 1'b1;
      pll_en_o     <= 1'b0;
      pll_rst_o    <= 1'b1;
      pll_dis_o    <= 1'b1;
      pll_pwrdn_o  <= 1'b1;
      prediv_o     <= '0;
      postdiv_o    <= '0;
      mult_o       <= '0;
      div_go_o     <= 1'b0;
    end else begin
      div_go_o <= (st_i == ST_GO);
      if (en_ref) begin
        ref_sq_o     <= cap_ref_q;
        en_src_pin_o <= 1'b0;
      end
      if (en_mux) pll_en_o    <= mux_d;
      if (en_rst) pll_rst_o   <= rst_d;
      if (en_dis) pll_dis_o   <= dis_d;
      if (en_pwr) pll_pwrdn_o <= 1'b0;
      if (en_pll) begin
        prediv_o  <= cap_pre_q;
        postdiv_o <= cap_post_q;
        mult_o    <= cap_mult_q;
      end
    end
  end

  // One register lane per output divider
  logic [ODIV_W-1:0] odiv_q [NUM_ODIV];

  for (genvar g = 0; g < NUM_ODIV; g++) begin : g_odiv
    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni)    odiv_q[g] <= '0;
      else if (en_od) odiv_q[g] <= cap_od_q[g*ODIV_W +: ODIV_W];
    end
    assign outdiv_o[g*ODIV_W +: ODIV_W] = odiv_q[g];
  end

  // Cycles spent with the mux in bypass, saturating; used only by a check
  logic [AGE_W-1:0] byp_age_q;
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)                 byp_age_q <= '0;
    else if (pll_en_o)           byp_age_q <= '0;
    else if (!(&byp_age_q))      byp_age_q <= byp_age_q + 1'b1;
  end

  AST_MUX_SETTLED: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(pll_rst_o) |-> (!pll_en_o && byp_age_q >= AGE_W'(MUX_CYC))); // R3
  AST_DIS_IN_RST: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(pll_dis_o) |-> pll_rst_o); // R4
  AST_PWRUP_ORDER: assert property (@(posedge clk) disable iff (!rst_ni)
    $fell(pll_pwrdn_o) |-> (pll_dis_o && pll_rst_o)); // R4
  AST_PLL_LOAD_LIVE: assert property (@(posedge clk) disable iff (!rst_ni)
    !$stable(mult_o) |-> (!pll_pwrdn_o && !pll_dis_o)); // R5
  AST_GO_PULSE: assert property (@(posedge clk) disable iff (!rst_ni)
    div_go_o |=> !div_go_o); // R6
  AST_GO_AFTER_ODIV: assert property (@(posedge clk) disable iff (!rst_ni)
    !$stable(outdiv_o) |=> div_go_o); // R6
  AST_EN_CLEAN: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(pll_en_o) |-> (!pll_rst_o && !pll_dis_o && !pll_pwrdn_o)); // R8
endmodule

// File: rtl/pll_seq_ctrl.sv
module pll_seq_ctrl
  import pll_seq_pkg::*;
#(
  parameter int unsigned REF_FREQ_HZ = 25_000_000,
  parameter int unsigned RST_US      = 5,
  parameter int unsigned MUX_CYC     = 4,
  parameter int unsigned LOCK_CYC    = 8000,
  parameter int unsigned PRE_W       = 5,
  parameter int unsigned POST_W      = 5,
  parameter int unsigned MULT_W      = 8,
  parameter int unsigned ODIV_W      = 5,
  parameter int unsigned NUM_ODIV    = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         req_valid,
  input  logic                         req_pll,
  input  logic                         req_ref_sq,
  input  logic [PRE_W-1:0]             req_prediv,
  input  logic [POST_W-1:0]            req_postdiv,
  input  logic [MULT_W-1:0]            req_mult,
  input  logic [NUM_ODIV*ODIV_W-1:0]   req_outdiv,
  output logic                         ref_sq,
  output logic                         en_src_pin,
  output logic                         pll_en,
  output logic                         pll_rst,
  output logic                         pll_dis,
  output logic                         pll_pwrdn,
  output logic [PRE_W-1:0]             prediv_o,
  output logic [POST_W-1:0]            postdiv_o,
  output logic [MULT_W-1:0]            mult_o,
  output logic [NUM_ODIV*ODIV_W-1:0]   outdiv_o,
  output logic                         div_go,
  output logic                         busy,
  output logic                         done
);
  localparam int unsigned RST_CYC  = us_to_cycles(64'(REF_FREQ_HZ), 64'(RST_US));
  localparam int unsigned MAX_A    = (MUX_CYC > RST_CYC) ? MUX_CYC : RST_CYC;
  localparam int unsigned MAX_CYC  = (MAX_A > LOCK_CYC) ? MAX_A : LOCK_CYC;
  localparam int unsigned TW       = $clog2(MAX_CYC) + 1;

  logic          rst_ni;
  logic          tmr_load;
  logic [TW-1:0] tmr_val;
  logic          tmr_zero;
  logic          accept;
  seq_st_e       st;

  pll_seq_rst_sync u_rst_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_no (rst_ni)
  );

  pll_seq_wait_timer #(.TW(TW)) u_timer (
    .clk    (clk),
    .rst_ni (rst_ni),
    .load_i (tmr_load),
    .val_i  (tmr_val),
    .zero_o (tmr_zero)
  );

  pll_seq_fsm #(
    .MUX_CYC (MUX_CYC),
    .RST_CYC (RST_CYC),
    .LOCK_CYC(LOCK_CYC),
    .TW      (TW)
  ) u_fsm (
    .clk         (clk),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid),
    .req_pll_i   (req_pll),
    .tmr_zero_i  (tmr_zero),
    .tmr_load_o  (tmr_load),
    .tmr_val_o   (tmr_val),
    .st_o        (st),
    .accept_o    (accept),
    .busy_o      (busy),
    .done_o      (done)
  );

  pll_seq_out_regs #(
    .MUX_CYC (MUX_CYC),
    .PRE_W   (PRE_W),
    .POST_W  (POST_W),
    .MULT_W  (MULT_W),
    .ODIV_W  (ODIV_W),
    .NUM_ODIV(NUM_ODIV)
  ) u_out (
    .clk           (clk),
    .rst_ni        (rst_ni),
    .st_i          (st),
    .accept_i      (accept),
    .req_ref_sq_i  (req_ref_sq),
    .req_prediv_i  (req_prediv),
    .req_postdiv_i (req_postdiv),
    .req_mult_i    (req_mult),
    .req_outdiv_i  (req_outdiv),
    .ref_sq_o      (ref_sq),
    .en_src_pin_o  (en_src_pin),
    .pll_en_o      (pll_en),
    .pll_rst_o     (pll_rst),
    .pll_dis_o     (pll_dis),
    .pll_pwrdn_o   (pll_pwrdn),
    .prediv_o      (prediv_o),
    .postdiv_o     (postdiv_o),
    .mult_o        (mult_o),
    .outdiv_o      (outdiv_o),
    .div_go_o      (div_go)
  );

  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_ni)
    $fell(busy) |-> done); // R10
endmodule

// File: tb/pll_seq_ctrl_tb_top.sv
`timescale 1ns/1ps
module pll_seq_ctrl_tb_top;
  localparam int unsigned FREQ = 2_000_000;
  localparam int unsigned M    = 4;
  localparam int unsigned L    = 20;
  localparam int unsigned R    = (FREQ * 5 + 999_999) / 1_000_000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_pll, req_ref_sq;
  logic [4:0]  req_prediv, req_postdiv;
  logic [7:0]  req_mult;
  logic [14:0] req_outdiv;
  logic        ref_sq, en_src_pin, pll_en, pll_rst, pll_dis, pll_pwrdn;
  logic [4:0]  prediv_o, postdiv_o;
  logic [7:0]  mult_o;
  logic [14:0] outdiv_o;
  logic        div_go, busy, done;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  pll_seq_ctrl #(
    .REF_FREQ_HZ(FREQ), .RST_US(5), .MUX_CYC(M), .LOCK_CYC(L)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_pll(req_pll),
    .req_ref_sq(req_ref_sq), .req_prediv(req_prediv), .req_postdiv(req_postdiv),
    .req_mult(req_mult), .req_outdiv(req_outdiv), .ref_sq(ref_sq),
    .en_src_pin(en_src_pin), .pll_en(pll_en), .pll_rst(pll_rst), .pll_dis(pll_dis),
    .pll_pwrdn(pll_pwrdn), .prediv_o(prediv_o), .postdiv_o(postdiv_o),
    .mult_o(mult_o), .outdiv_o(outdiv_o), .div_go(div_go), .busy(busy), .done(done)
  );

  // Model of the resting output state between runs
  logic       m_ref, m_src, m_en, m_rst, m_dis, m_pwd;
  logic [4:0] m_pre, m_post;
  logic [7:0] m_mult;
  logic [14:0] m_od;

  task automatic chk(input string tag, input longint act, input longint exp, input int t);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s t=%0d actual=%0h expected=%0h", tag, t, act, exp);
    end
  endtask

  task automatic model_reset();
    m_ref = 0; m_src = 1; m_en = 0; m_rst = 1; m_dis = 1; m_pwd = 1;
    m_pre = 0; m_post = 0; m_mult = 0; m_od = 0;
  endtask

  task automatic chk_reset_state();
    chk("R1 pll_en", pll_en, 0, 0);      chk("R1 pll_rst", pll_rst, 1, 0);
    chk("R1 pll_dis", pll_dis, 1, 0);    chk("R1 pll_pwrdn", pll_pwrdn, 1, 0);
    chk("R1 div_go", div_go, 0, 0);      chk("R1 busy", busy, 0, 0);
    chk("R1 done", done, 0, 0);          chk("R1 ref_sq", ref_sq, 0, 0);
    chk("R1 en_src_pin", en_src_pin, 1, 0);
    chk("R1 dividers", {prediv_o, postdiv_o, mult_o, outdiv_o}, 0, 0);
  endtask

  // Issue one request and compare every output on every cycle to the model.
  task automatic run_req(input bit pll, input bit rf, input logic [4:0] pre,
                         input logic [4:0] post, input logic [7:0] mu,
                         input logic [14:0] od, input bit poke);
    int tdone;
    logic e_ref, e_src, e_en, e_rst, e_dis, e_pwd, e_go;
    logic [4:0] e_pre, e_post;
    logic [7:0] e_mult;
    logic [14:0] e_od;
    @(negedge clk);
    req_pll = pll; req_ref_sq = rf; req_prediv = pre; req_postdiv = post;
    req_mult = mu; req_outdiv = od; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    tdone = pll ? int'(13 + M + R + L) : int'(7 + M);
    for (int t = 1; t <= tdone + 1; t++) begin
      if (t > 1) @(negedge clk);
      e_ref = (t >= 2) ? rf : m_ref;
      e_src = (t >= 2) ? 1'b0 : m_src;
      e_en  = (t >= 3) ? 1'b0 : m_en;
      e_rst = (t >= int'(4 + M)) ? 1'b1 : m_rst;
      e_dis = m_dis; e_pwd = m_pwd;
      e_pre = m_pre; e_post = m_post; e_mult = m_mult; e_od = m_od;
      if (pll) begin
        if (t >= int'(5 + M)) e_dis = 1'b1;
        if (t >= int'(6 + M)) e_pwd = 1'b0;
        if (t >= int'(7 + M)) e_dis = 1'b0;
        if (t >= int'(8 + M)) begin e_pre = pre; e_post = post; e_mult = mu; end
        if (t >= int'(9 + M)) e_od = od;
        if (t >= int'(11 + M + R)) e_rst = 1'b0;
        if (t >= int'(12 + M + R + L)) e_en = 1'b1;
        e_go = (t == int'(10 + M));
      end else begin
        if (t >= int'(5 + M)) e_od = od;
        e_go = (t == int'(6 + M));
      end
      chk("R2 ref_sq", ref_sq, e_ref, t);
      chk("R2 en_src_pin", en_src_pin, e_src, t);
      chk("R3/R8 pll_en", pll_en, e_en, t);
      chk("R3/R7 pll_rst", pll_rst, e_rst, t);
      chk("R4/R9 pll_dis", pll_dis, e_dis, t);
      chk("R4/R9 pll_pwrdn", pll_pwrdn, e_pwd, t);
      chk("R5/R9 pll_divs", {prediv_o, postdiv_o, mult_o}, {e_pre, e_post, e_mult}, t);
      chk("R5/R11 outdiv", outdiv_o, e_od, t);
      chk("R6 div_go", div_go, e_go, t);
      chk("R10 busy", busy, (t < tdone), t);
      chk("R10 done", done, (t == tdone), t);
      // R11: stray request while busy, with every field different
      if (poke && t == 5) begin
        req_pll = ~pll; req_ref_sq = ~rf; req_prediv = ~pre; req_postdiv = ~post;
        req_mult = ~mu; req_outdiv = ~od; req_valid = 1'b1;
      end else begin
        req_valid = 1'b0;
      end
    end
    m_ref = rf; m_src = 0; m_en = pll; m_rst = !pll; m_od = od;
    if (pll) begin m_dis = 0; m_pwd = 0; m_pre = pre; m_post = post; m_mult = mu; end
  endtask

  initial begin
    #(5.0 * 200000);
    n_err++;
    $display("FAIL watchdog expired actual=running expected=finished");
    if (!finished) $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    rst_n = 0; req_valid = 0; req_pll = 0; req_ref_sq = 0;
    req_prediv = 0; req_postdiv = 0; req_mult = 0; req_outdiv = 0;
    model_reset();
    repeat (3) @(negedge clk);
    chk_reset_state();  // R1 during reset
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk_reset_state();  // R1 after release

    // Sweep: PLL/bypass interleaved, both reference types, divider patterns
    for (int k = 0; k < 4; k++) begin
      for (int rf = 0; rf < 2; rf++) begin
        for (int p = 1; p >= 0; p--) begin
          run_req(p[0], rf[0], 5'(k * 7 + 1 + p), 5'(31 - k * 5 - rf),
                  8'(k * 53 + rf * 17 + 3), 15'(k * 4099 + rf * 611 + p * 77 + 1),
                  (k == 1) || (k == 3 && rf == 1));
        end
      end
    end

    // Reset in the middle of a PLL bring-up
    @(negedge clk);
    req_pll = 1; req_ref_sq = 1; req_prediv = 5'h11; req_postdiv = 5'h0a;
    req_mult = 8'h5c; req_outdiv = 15'h1234; req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    repeat (12) @(negedge clk);
    rst_n = 0;
    #1;
    chk_reset_state();  // R1 asynchronous
    @(negedge clk);
    rst_n = 1;
    model_reset();
    repeat (3) @(negedge clk);
    chk_reset_state();  // R1 idle again
    run_req(0, 1, 5'h03, 5'h04, 8'h05, 15'h7abc, 0);
    run_req(1, 0, 5'h1f, 5'h01, 8'hff, 15'h0001, 1);

    repeat (2) @(negedge clk);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule